// File: doc/BRIEF.md
# DMA Event Status and Interrupt Mask Register

This block keeps the event flags and interrupt masks of a ten-channel DMA controller in one 32-bit register. Each transfer channel raises a pulse when it finishes or gives up on an address fault, and the matching flag latches. A separate pulse latches a bus-error flag. Software reads the whole register and writes it to acknowledge events or change masks.

A write is not a plain store. A one in the lower half clears that flag, and a one in the upper half flips that mask bit. A zero leaves the bit alone, so separate agents can acknowledge their own events without a read-modify-write. Two bus addresses decode to the register, and both behave the same. The block drives one interrupt request. It is high whenever an enabled channel flag is pending or the bus-error flag is set.

Top module: `dma_event_status`

## Requirements
- R1: After the active-low reset `rd_data_o` reads all zeros and `irq_o` is low.
- R2: A high `chan_done_i[n]` at a clock edge sets flag n, which is bit n of `rd_data_o`, from that edge on, for n from 0 to 9.
- R3: A high `bus_err_i` at a clock edge sets the bus-error flag, which is bit 15 of `rd_data_o`.
- R4: A register write clears each flag whose bit in `wr_data_i[15:0]` is one. Flags whose write bit is zero keep their value.
- R5: A register write inverts mask bit n, which is bit 16+n of `rd_data_o`, for each one in `wr_data_i[16+n]`. Mask bits whose write bit is zero keep their value.
- R6: A write to `ALIAS_ADDR` (default 0x11) has exactly the same effect as a write to `MAIN_ADDR` (default 0x10).
- R7: A cycle with `wr_en_i` low, or with any other address, changes no flag and no mask bit.
- R8: When a set pulse and a write clear hit the same flag in the same cycle, the flag ends up set.
- R9: `irq_o` is high exactly when some flag n has its mask bit n set, or when the bus-error flag is set. It follows the register contents in the same cycle, so it reflects a write from the next cycle on.
- R10: Bits 10 to 14 and 26 to 31 of `rd_data_o` always read zero, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Single-cycle register write strobe |
| wr_addr_i | input | 8 | Write address, compared with the main and alias addresses |
| wr_data_i | input | 32 | Write data: clear bits in the low half, toggle bits in the high half |
| chan_done_i | input | 10 | Per-channel finish or fault pulses |
| bus_err_i | input | 1 | Bus-error event pulse |
| rd_data_o | output | 32 | Current register value |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a collision in one cycle. It happens when a channel pulse lands on the same flag that a write is clearing, while the same write flips that channel's mask. The result then depends on the set-over-clear priority and on the new mask value together. The bench steers into this case on purpose, and it also drives the alias address and decoy addresses. After the directed cases, a pseudo-random stream mixes pulses, toggles and clears across all three addresses. A behavioural model is compared with the outputs after every clock.

// File: rtl/dma_stat_pkg.sv
package dma_stat_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned HALF_W   = REG_W / 2;
  localparam int unsigned BERR_POS = HALF_W - 1;  // top bit of the flag half
  typedef logic [REG_W-1:0] reg_t;
endpackage

// File: rtl/dma_stat_wdec.sv
module dma_stat_wdec
  import dma_stat_pkg::*;
#(
  parameter int unsigned          NUM_CH     = 10,
  parameter int unsigned          ADDR_W     = 8,
  parameter logic [ADDR_W-1:0]    MAIN_ADDR  = 8'h10,
  parameter logic [ADDR_W-1:0]    ALIAS_ADDR = 8'h11
) (
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  reg_t              wr_data_i,
  output logic [NUM_CH-1:0] clr_ch_o,
  output logic              clr_berr_o,
  output logic [NUM_CH-1:0] tgl_ch_o
);
  logic hit;
  logic unused_rsvd;

  assign hit = wr_en_i && ((wr_addr_i == MAIN_ADDR) || (wr_addr_i == ALIAS_ADDR));

  always_comb begin
    clr_ch_o   = '0;
    clr_berr_o = 1'b0;
    tgl_ch_o   = '0;
    if (hit) begin
      clr_ch_o   = wr_data_i[NUM_CH-1:0];
      clr_berr_o = wr_data_i[BERR_POS];
      tgl_ch_o   = wr_data_i[HALF_W +: NUM_CH];
    end
  end

  // reserved write bits are dropped
  assign unused_rsvd = ^wr_data_i;
endmodule

// File: rtl/dma_stat_flags.sv
module dma_stat_flags #(
  parameter int unsigned NUM_CH = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] set_ch_i,
  input  logic              set_berr_i,
  input  logic [NUM_CH-1:0] clr_ch_i,
  input  logic              clr_berr_i,
  output logic [NUM_CH-1:0] flag_o,
  output logic              berr_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          flag_o[g] <= 1'b0;
      else if (set_ch_i[g]) flag_o[g] <= 1'b1;  // set beats clear
      else if (clr_ch_i[g]) flag_o[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         berr_o <= 1'b0;
    else if (set_berr_i) berr_o <= 1'b1;
    else if (clr_berr_i) berr_o <= 1'b0;
  end
endmodule

// File: rtl/dma_stat_mask.sv
module dma_stat_mask #(
  parameter int unsigned NUM_CH = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] tgl_ch_i,
  output logic [NUM_CH-1:0] mask_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          mask_o[g] <= 1'b0;
      else if (tgl_ch_i[g]) mask_o[g] <= ~mask_o[g];
    end
  end
endmodule

// File: rtl/dma_stat_irq.sv
module dma_stat_irq #(
  parameter int unsigned NUM_CH = 10
) (
  input  logic [NUM_CH-1:0] flag_i,
  input  logic [NUM_CH-1:0] mask_i,
  input  logic              berr_i,
  output logic              irq_o
);
  assign irq_o = (|(flag_i & mask_i)) | berr_i;
endmodule

// File: rtl/dma_event_status.sv
module dma_event_status
  import dma_stat_pkg::*;
#(
  parameter int unsigned       NUM_CH     = 10,
  parameter int unsigned       ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] MAIN_ADDR  = 8'h10,
  parameter logic [ADDR_W-1:0] ALIAS_ADDR = 8'h11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [31:0]       wr_data_i,
  input  logic [NUM_CH-1:0] chan_done_i,
  input  logic              bus_err_i,
  output logic [31:0]       rd_data_o,
  output logic              irq_o
);
  logic [NUM_CH-1:0] clr_ch, tgl_ch, flag, mask;
  logic              clr_berr, berr;

  dma_stat_wdec #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .MAIN_ADDR(MAIN_ADDR), .ALIAS_ADDR(ALIAS_ADDR)
  ) u_wdec (
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .clr_ch_o  (clr_ch),
    .clr_berr_o(clr_berr),
    .tgl_ch_o  (tgl_ch)
  );

  dma_stat_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_ch_i  (chan_done_i),
    .set_berr_i(bus_err_i),
    .clr_ch_i  (clr_ch),
    .clr_berr_i(clr_berr),
    .flag_o    (flag),
    .berr_o    (berr)
  );

  dma_stat_mask #(.NUM_CH(NUM_CH)) u_mask (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tgl_ch_i(tgl_ch),
    .mask_o  (mask)
  );

  dma_stat_irq #(.NUM_CH(NUM_CH)) u_irq (
    .flag_i(flag),
    .mask_i(mask),
    .berr_i(berr),
    .irq_o (irq_o)
  );

  always_comb begin
    rd_data_o                   = '0;
    rd_data_o[NUM_CH-1:0]       = flag;
    rd_data_o[BERR_POS]         = berr;
    rd_data_o[HALF_W +: NUM_CH] = mask;
  end
endmodule

// File: rtl/dma_stat_chk.sv
module dma_stat_chk
  import dma_stat_pkg::*;
#(
  parameter int unsigned       NUM_CH     = 10,
  parameter int unsigned       ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] MAIN_ADDR  = 8'h10,
  parameter logic [ADDR_W-1:0] ALIAS_ADDR = 8'h11
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [31:0]       wr_data_i,
  input logic [NUM_CH-1:0] chan_done_i,
  input logic              bus_err_i,
  input logic [31:0]       rd_data_o,
  input logic              irq_o
);
  logic hit;
  assign hit = wr_en_i && ((wr_addr_i == MAIN_ADDR) || (wr_addr_i == ALIAS_ADDR));

  p_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|chan_done_i) |=> ((rd_data_o[NUM_CH-1:0] & $past(chan_done_i)) == $past(chan_done_i)));

  p_berr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_err_i |=> rd_data_o[BERR_POS]);

  p_clr_berr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && wr_data_i[BERR_POS] && !bus_err_i) |=> !rd_data_o[BERR_POS]);

  p_toggle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> (rd_data_o[HALF_W +: NUM_CH] ==
             $past(rd_data_o[HALF_W +: NUM_CH] ^ wr_data_i[HALF_W +: NUM_CH])));

  p_alias_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_addr_i == ALIAS_ADDR && !(|chan_done_i) && !bus_err_i) |=>
      (rd_data_o[NUM_CH-1:0] == $past(rd_data_o[NUM_CH-1:0] & ~wr_data_i[NUM_CH-1:0])));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> $stable(rd_data_o[HALF_W +: NUM_CH]));

  p_setwins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chan_done_i[0] && hit && wr_data_i[0]) |=> rd_data_o[0]);

  p_irq_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == ((|(rd_data_o[NUM_CH-1:0] & rd_data_o[HALF_W +: NUM_CH])) | rd_data_o[BERR_POS]));

  p_rsvd_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_data_o[BERR_POS-1:NUM_CH] == '0) && (rd_data_o[REG_W-1:HALF_W+NUM_CH] == '0));
endmodule

bind dma_event_status dma_stat_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .MAIN_ADDR(MAIN_ADDR), .ALIAS_ADDR(ALIAS_ADDR)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .wr_data_i  (wr_data_i),
  .chan_done_i(chan_done_i),
  .bus_err_i  (bus_err_i),
  .rd_data_o  (rd_data_o),
  .irq_o      (irq_o)
);

// File: tb/dma_event_status_tb_top.sv
module dma_event_status_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [9:0]  chan_done_i = '0;
  logic        bus_err_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        irq_o;

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] m_flag = '0;
  logic [15:0] m_mask = '0;

  always #5 clk_i = ~clk_i;

  dma_event_status dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .chan_done_i(chan_done_i), .bus_err_i(bus_err_i),
    .rd_data_o(rd_data_o), .irq_o(irq_o)
  );

  task automatic compare(input string tag);
    logic [31:0] exp_rd;
    logic        exp_irq;
    exp_rd  = {m_mask, m_flag};
    exp_irq = (|(m_flag[9:0] & m_mask[9:0])) | m_flag[15];
    n_run++;
    if (rd_data_o !== exp_rd) begin
      n_fail++;
      $display("FAIL %s rd_data act=%h exp=%h", tag, rd_data_o, exp_rd);
    end
    n_run++;
    if (irq_o !== exp_irq) begin
      n_fail++;
      $display("FAIL %s irq act=%b exp=%b", tag, irq_o, exp_irq);
    end
  endtask

  // called at a falling edge; applies one cycle of stimulus, then compares
  task automatic step(input logic [9:0] done, input logic be, input logic we,
                      input logic [7:0] addr, input logic [31:0] data, input string tag);
    chan_done_i = done; bus_err_i = be; wr_en_i = we; wr_addr_i = addr; wr_data_i = data;
    if (we && (addr == 8'h10 || addr == 8'h11)) begin
      m_flag = m_flag & ~data[15:0];
      m_mask = m_mask ^ data[31:16];
    end
    m_flag = m_flag | {6'b0, done};
    if (be) m_flag[15] = 1'b1;
    m_flag = m_flag & 16'h83FF;
    m_mask = m_mask & 16'h03FF;
    @(posedge clk_i);
    @(negedge clk_i);
    chan_done_i = '0; bus_err_i = 1'b0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
    compare(tag);
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] lfsr;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    compare("R1 reset");
    step(10'h001, 0, 0, 8'h00, 32'h0, "R2 ch0");
    step(10'h200, 0, 0, 8'h00, 32'h0, "R2 ch9");
    step(10'h154, 0, 0, 8'h00, 32'h0, "R2 multi");
    step(10'h000, 1, 0, 8'h00, 32'h0, "R3 berr");
    step(10'h000, 0, 1, 8'h10, 32'h8000_0000, "R10 rsvd mask bit");
    step(10'h000, 0, 1, 8'h10, 32'h0000_8000, "R4 clear berr");
    step(10'h000, 0, 1, 8'h10, 32'h0001_0000, "R9 mask raises irq");
    step(10'h000, 0, 1, 8'h10, 32'h0000_0001, "R9 clear drops irq");
    step(10'h000, 0, 1, 8'h10, 32'h0000_0004, "R4 clear one");
    step(10'h000, 0, 1, 8'h10, 32'h0203_0000, "R5 toggle on");
    step(10'h000, 0, 1, 8'h10, 32'h0002_0000, "R5 toggle off");
    step(10'h000, 0, 1, 8'h11, 32'h0000_0200, "R6 alias clear");
    step(10'h000, 0, 1, 8'h11, 32'h0050_0000, "R6 alias toggle");
    step(10'h000, 0, 1, 8'h33, 32'hFFFF_FFFF, "R7 other addr");
    step(10'h000, 0, 0, 8'h10, 32'hFFFF_FFFF, "R7 no strobe");
    step(10'h008, 0, 1, 8'h10, 32'h0008_0008, "R8 set beats clear");
    step(10'h000, 1, 1, 8'h11, 32'h0000_8000, "R8 berr beats clear");
    step(10'h000, 0, 1, 8'h10, 32'hFC00_7C00, "R10 rsvd write");
    step(10'h000, 0, 1, 8'h10, 32'h0000_FFFF, "R4 clear all");
    lfsr = 32'hACE1_2357;
    for (int i = 0; i < 80; i++) begin
      logic [7:0] a;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = (lfsr[3:2] == 2'd0) ? 8'h10 : (lfsr[3:2] == 2'd1) ? 8'h11 : 8'h12;
      step(lfsr[9:0] & lfsr[19:10], lfsr[31] & lfsr[30] & lfsr[29], lfsr[4],
           a, {lfsr[15:0], lfsr[31:16]}, "R9 mixed");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule